// File: doc/BRIEF.md
# Wrapping Hardware Stack Engine

This block holds the stack pointer and drives the stack storage for a small 8-bit processor core. The core hands it byte pushes and pops, subroutine call and return, interrupt entry and return, a command that puts the pointer back to the top, and direct loads of the pointer's low byte. Transfers of several bytes run one byte per clock. A busy flag and a one-cycle done pulse tell the core when a transfer is over.

The pointer is 16 bits wide when read, but only its low 7 bits are state. The upper 9 bits are tied so that the pointer always lies in the window 0x0180..0x01FF, and 128 bytes of RAM are indexed by the low bits. The pointer always addresses the next free slot. A push writes there and then steps down. A pop steps up and then reads. Stepping past either end of the window wraps to the other end with no warning, and the older data at that slot is overwritten.

Top module: `stack_engine`

## Requirements
- R1: `sp_out` is always {9'b0_0000_0001_1, idx} with idx the 7-bit pointer state, so it stays within 0x0180..0x01FF. After a synchronous `rst` it reads 0x01FF.
- R2: A request is taken when `req_valid` is high and `busy` is low. The op codes on `req_op` are 0 none, 1 PUSH, 2 POP, 3 CALL, 4 RET, 5 INT, 6 IRET, 7 RSP. PUSH writes `push_data` at the current pointer and then decrements it. POP increments the pointer and then reads, and the byte is on `pop_data` after that same edge.
- R3: The pointer wraps silently. One decrement from 0x0180 gives 0x01FF, and one increment from 0x01FF gives 0x0180. After 129 consecutive pushes from 0x01FF the pointer reads 0x01FE, and the 129th byte has replaced the first.
- R4: RSP sets the pointer to 0x01FF and gives a done pulse.
- R5: When `sp_ld` is high, `busy` is low and `req_valid` is low, bits 6..0 of `sp_ld_val` are loaded into the pointer. Bit 7 has no effect. A load on a cycle with `req_valid` high is ignored.
- R6: CALL pushes PCL and then PCH of `pc_in` (2 bytes). RET pops PCH and then PCL into `ret_pc`.
- R7: INT pushes PCL, PCH, X, A and CC in that order, at descending addresses (5 bytes). IRET pops CC, A, X, PCH and PCL, which restores `ret_pc`, `ret_x`, `ret_a` and `ret_cc`.
- R8: An n-byte request moves one byte per clock, starting on the accepting edge. `busy` is high after each of the first n-1 byte edges. `done` is high for exactly the one cycle after the last byte's edge. Single-byte requests never raise `busy`.
- R9: While `busy` is high, a request is ignored. A request with op code 0 is ignored as well, and it gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request op code |
| push_data | input | 8 | Byte for PUSH |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| sp_ld | input | 1 | Load pointer low byte |
| sp_ld_val | input | 8 | Value for pointer low byte |
| busy | output | 1 | Multi-byte transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Full 16-bit stack pointer |
| pop_data | output | 8 | Byte from last POP |
| ret_pc | output | 16 | Program counter restored by RET/IRET |
| ret_x | output | 8 | X restored by IRET |
| ret_a | output | 8 | Accumulator restored by IRET |
| ret_cc | output | 8 | Condition codes restored by IRET |

## Verification
The assertions assume that the core raises `req_valid` only as a single request and that context inputs are stable on the accepting edge. They also assume that the pointer checks apply on cycles where the request is a single-byte push or pop. The stimulus issues each multi-byte request for one cycle and then waits for `busy` to fall. Where it deliberately drives a request during `busy`, that is to exercise R9. Back-to-back pushes and pops are issued only as single-byte ops, which never raise `busy`.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_AW    = 7;
    localparam int STK_DW    = 8;
    localparam int STK_DEPTH = 1 << STK_AW;
    localparam logic [15:0] STK_BASE = 16'(32'h0200 - STK_DEPTH);

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_INT  = 3'd5,
        OP_IRET = 3'd6,
        OP_RSP  = 3'd7
    } stk_op_e;

    typedef enum logic [2:0] {
        DST_BYTE = 3'd0,
        DST_PCL  = 3'd1,
        DST_PCH  = 3'd2,
        DST_X    = 3'd3,
        DST_A    = 3'd4,
        DST_CC   = 3'd5
    } stk_dst_e;

    typedef struct packed {
        logic [7:0] pcl;
        logic [7:0] pch;
        logic [7:0] x;
        logic [7:0] a;
        logic [7:0] cc;
    } stk_ctx_t;

    function automatic logic [2:0] op_len(stk_op_e op);
        case (op)
            OP_NOP:           return 3'd0;
            OP_CALL, OP_RET:  return 3'd2;
            OP_INT, OP_IRET:  return 3'd5;
            default:          return 3'd1;
        endcase
    endfunction

    function automatic logic op_writes(stk_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL) || (op == OP_INT);
    endfunction

    function automatic logic op_reads(stk_op_e op);
        return (op == OP_POP) || (op == OP_RET) || (op == OP_IRET);
    endfunction

    function automatic stk_dst_e pop_dst(stk_op_e op, logic [2:0] step);
        if (op == OP_RET)
            return (step == 3'd0) ? DST_PCH : DST_PCL;
        if (op == OP_IRET) begin
            case (step)
                3'd0:    return DST_CC;
                3'd1:    return DST_A;
                3'd2:    return DST_X;
                3'd3:    return DST_PCH;
                default: return DST_PCL;
            endcase
        end
        return DST_BYTE;
    endfunction

    function automatic logic [7:0] push_byte(stk_op_e op, logic [2:0] step,
                                             stk_ctx_t ctx, logic [7:0] data);
        if (op == OP_PUSH)
            return data;
        case (step)
            3'd0:    return ctx.pcl;
            3'd1:    return ctx.pch;
            3'd2:    return ctx.x;
            3'd3:    return ctx.a;
            default: return ctx.cc;
        endcase
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int AW = stk_pkg::STK_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rsp,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          dec,
    input  logic          inc,
    output logic [AW-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst || rsp)
            idx <= '1;
        else if (ld)
            idx <= ld_val;
        else if (dec)
            idx <= idx - 1'b1;
        else if (inc)
            idx <= idx + 1'b1;
    end

endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int AW = stk_pkg::STK_AW,
    parameter int DW = stk_pkg::STK_DW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [7:0] push_data,
    input  stk_ctx_t   ctx_in,
    input  logic       sp_ld,
    input  logic [7:0] rd_byte,
    output logic       p_rsp,
    output logic       p_ld,
    output logic       p_dec,
    output logic       p_inc,
    output logic       ram_we,
    output logic [7:0] ram_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] pop_data,
    output stk_ctx_t   res
);

    logic       active_q;
    stk_op_e    op_q;
    logic [2:0] step_q;
    stk_ctx_t   ctx_q;

    stk_op_e    cur_op;
    logic [2:0] cur_step;
    stk_ctx_t   cur_ctx;
    logic       accept;
    logic       fire;
    logic       last;
    stk_dst_e   dst;

    always_comb begin
        accept   = !active_q && req_valid && (stk_op_e'(req_op) != OP_NOP);
        cur_op   = active_q ? op_q   : stk_op_e'(req_op);
        cur_step = active_q ? step_q : 3'd0;
        cur_ctx  = active_q ? ctx_q  : ctx_in;
        fire     = active_q || accept;
        last     = (cur_step == (op_len(cur_op) - 3'd1));
        dst      = pop_dst(cur_op, cur_step);
        p_dec    = fire && op_writes(cur_op);
        p_inc    = fire && op_reads(cur_op);
        p_rsp    = fire && (cur_op == OP_RSP);
        p_ld     = sp_ld && !active_q && !req_valid;
        ram_we   = p_dec;
        ram_wdata = push_byte(cur_op, cur_step, cur_ctx, push_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= OP_NOP;
            step_q   <= 3'd0;
            ctx_q    <= '0;
            done     <= 1'b0;
            pop_data <= '0;
            res      <= '0;
        end else begin
            done <= fire && last;
            if (fire) begin
                active_q <= !last;
                op_q     <= cur_op;
                step_q   <= cur_step + 3'd1;
                ctx_q    <= cur_ctx;
                if (p_inc) begin
                    case (dst)
                        DST_PCL: res.pcl  <= rd_byte;
                        DST_PCH: res.pch  <= rd_byte;
                        DST_X:   res.x    <= rd_byte;
                        DST_A:   res.a    <= rd_byte;
                        DST_CC:  res.cc   <= rd_byte;
                        default: pop_data <= rd_byte;
                    endcase
                end
            end
        end
    end

    assign busy = active_q;

endmodule

// File: rtl/stack_engine.sv
module stack_engine
    import stk_pkg::*;
#(
    parameter int AW = STK_AW,
    parameter int DW = STK_DW
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [7:0]  push_data,
    input  logic [15:0] pc_in,
    input  logic [7:0]  x_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  cc_in,
    input  logic        sp_ld,
    input  logic [7:0]  sp_ld_val,
    output logic        busy,
    output logic        done,
    output logic [15:0] sp_out,
    output logic [7:0]  pop_data,
    output logic [15:0] ret_pc,
    output logic [7:0]  ret_x,
    output logic [7:0]  ret_a,
    output logic [7:0]  ret_cc
);

    logic [AW-1:0] idx;
    logic          p_rsp, p_ld, p_dec, p_inc;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] rd_byte;
    stk_ctx_t      ctx_in;
    stk_ctx_t      res;

    assign ctx_in = '{pcl: pc_in[7:0], pch: pc_in[15:8], x: x_in, a: a_in, cc: cc_in};

    stk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .push_data (push_data),
        .ctx_in    (ctx_in),
        .sp_ld     (sp_ld),
        .rd_byte   (rd_byte),
        .p_rsp     (p_rsp),
        .p_ld      (p_ld),
        .p_dec     (p_dec),
        .p_inc     (p_inc),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .busy      (busy),
        .done      (done),
        .pop_data  (pop_data),
        .res       (res)
    );

    stk_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .rsp    (p_rsp),
        .ld     (p_ld),
        .ld_val (sp_ld_val[AW-1:0]),
        .dec    (p_dec),
        .inc    (p_inc),
        .idx    (idx)
    );

    stk_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (idx),
        .wdata (ram_wdata),
        .raddr (idx + 1'b1),
        .rdata (rd_byte)
    );

    assign sp_out = STK_BASE | 16'(idx);
    assign ret_pc = {res.pch, res.pcl};
    assign ret_x  = res.x;
    assign ret_a  = res.a;
    assign ret_cc = res.cc;

endmodule

// File: rtl/stk_chk.sv
module stk_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic        sp_ld,
    input logic [7:0]  sp_ld_val,
    input logic        busy,
    input logic        done,
    input logic [15:0] sp_out
);

    logic take;
    assign take = req_valid && !busy;

    AST_PTR_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (sp_out >= 16'h0180) && (sp_out <= 16'h01FF)); // R1

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd1) |=> (sp_out[6:0] == $past(sp_out[6:0]) - 7'd1)); // R3

    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd2) |=> (sp_out[6:0] == $past(sp_out[6:0]) + 7'd1)); // R2

    AST_RSP_TOP: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd7) |=> (sp_out == 16'h01FF && done)); // R4

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (sp_ld && !busy && !req_valid) |=> (sp_out[6:0] == $past(sp_ld_val[6:0]))); // R5

    AST_CALL_LEN: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd3) |=> (busy && !done) ##1 (done && !busy)); // R6

    AST_INT_LEN: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd5) |=> busy ##1 busy ##1 busy ##1 busy ##1 (done && !busy)); // R7

    AST_BUSY_MOVES: assert property (@(posedge clk) disable iff (rst)
        busy |=> (sp_out != $past(sp_out))); // R8

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd0) |=> (!done && $stable(sp_out))); // R9

endmodule

bind stack_engine stk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .sp_ld     (sp_ld),
    .sp_ld_val (sp_ld_val),
    .busy      (busy),
    .done      (done),
    .sp_out    (sp_out)
);

// File: tb/tb_stack_engine.sv
module tb_stack_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  push_data = 8'd0;
    logic [15:0] pc_in = 16'd0;
    logic [7:0]  x_in = 8'd0, a_in = 8'd0, cc_in = 8'd0;
    logic        sp_ld = 1'b0;
    logic [7:0]  sp_ld_val = 8'd0;
    logic        busy, done;
    logic [15:0] sp_out, ret_pc;
    logic [7:0]  pop_data, ret_x, ret_a, ret_cc;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit ended  = 1'b0;

    stack_engine dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .push_data(push_data), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
        .cc_in(cc_in), .sp_ld(sp_ld), .sp_ld_val(sp_ld_val), .busy(busy),
        .done(done), .sp_out(sp_out), .pop_data(pop_data), .ret_pc(ret_pc),
        .ret_x(ret_x), .ret_a(ret_a), .ret_cc(ret_cc)
    );

    always #10 clk = ~clk;

    // reference model
    int         m_sp;
    logic [7:0] m_mem [128];
    int         q[$];
    logic       e_busy, e_done;
    logic [7:0] e_pop, e_x, e_a, e_cc, e_pcl, e_pch;

    task automatic m_exec(int act);
        int v;
        if ((act >> 8) == 1) begin
            m_mem[m_sp] = act[7:0];
            m_sp = (m_sp + 127) % 128;
        end else begin
            m_sp = (m_sp + 1) % 128;
            v = m_mem[m_sp];
            case (act & 255)
                1: e_pcl = v[7:0];
                2: e_pch = v[7:0];
                3: e_x   = v[7:0];
                4: e_a   = v[7:0];
                5: e_cc  = v[7:0];
                default: e_pop = v[7:0];
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sp = 127; q.delete();
            e_busy = 0; e_done = 0; e_pop = 0;
            e_x = 0; e_a = 0; e_cc = 0; e_pcl = 0; e_pch = 0;
        end else begin
            e_done = 0;
            if (q.size() == 0) begin
                if (req_valid) begin
                    case (req_op)
                        3'd1: q.push_back(256 | push_data);
                        3'd2: q.push_back(512);
                        3'd3: begin q.push_back(256 | pc_in[7:0]); q.push_back(256 | pc_in[15:8]); end
                        3'd4: begin q.push_back(512 | 2); q.push_back(512 | 1); end
                        3'd5: begin
                            q.push_back(256 | pc_in[7:0]); q.push_back(256 | pc_in[15:8]);
                            q.push_back(256 | x_in); q.push_back(256 | a_in); q.push_back(256 | cc_in);
                        end
                        3'd6: begin
                            q.push_back(512 | 5); q.push_back(512 | 4); q.push_back(512 | 3);
                            q.push_back(512 | 2); q.push_back(512 | 1);
                        end
                        3'd7: begin m_sp = 127; e_done = 1; end
                        default: ;
                    endcase
                end else if (sp_ld) begin
                    m_sp = sp_ld_val & 127;
                end
            end
            if (q.size() > 0) begin
                m_exec(q.pop_front());
                if (q.size() == 0) e_done = 1;
            end
            e_busy = (q.size() > 0);
        end
    end

    task automatic chk(string req, string what, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (chk_en && !ended) begin
            chk("R1", "sp_out", sp_out === (16'h0180 | 16'(m_sp)), sp_out, 16'h0180 | m_sp);
            chk("R8", "busy", busy === e_busy, busy, e_busy);
            chk("R8", "done", done === e_done, done, e_done);
            chk("R2", "pop_data", pop_data === e_pop, pop_data, e_pop);
            chk("R6", "ret_pc", ret_pc === {e_pch, e_pcl}, ret_pc, {e_pch, e_pcl});
            chk("R7", "ret_x", ret_x === e_x, ret_x, e_x);
            chk("R7", "ret_a", ret_a === e_a, ret_a, e_a);
            chk("R7", "ret_cc", ret_cc === e_cc, ret_cc, e_cc);
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic do_op(logic [2:0] op, logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; push_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        while (busy) @(negedge clk);
    endtask

    logic [15:0] sp_save;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;
        @(negedge clk);
        chk("R1", "reset sp", sp_out === 16'h01FF, sp_out, 16'h01FF);

        // R2 basic push/pop
        do_op(3'd1, 8'h11); do_op(3'd1, 8'h22); do_op(3'd1, 8'h33);
        chk("R2", "sp after pushes", sp_out === 16'h01FC, sp_out, 16'h01FC);
        do_op(3'd2, 0);
        chk("R2", "first pop", pop_data === 8'h33, pop_data, 8'h33);
        do_op(3'd2, 0); do_op(3'd2, 0);
        chk("R2", "last pop", pop_data === 8'h11, pop_data, 8'h11);

        // R6 call/ret
        pc_in = 16'hBEEF;
        do_op(3'd3, 0);
        pc_in = 16'h0000;
        do_op(3'd4, 0);
        chk("R6", "ret pc", ret_pc === 16'hBEEF, ret_pc, 16'hBEEF);

        // R7 interrupt entry and return
        pc_in = 16'h1234; x_in = 8'h55; a_in = 8'h66; cc_in = 8'h0A;
        do_op(3'd5, 0);
        chk("R7", "sp after int", sp_out === 16'h01FA, sp_out, 16'h01FA);
        pc_in = 16'hFFFF; x_in = 8'h00; a_in = 8'h00; cc_in = 8'h00;
        do_op(3'd6, 0);
        chk("R7", "iret ctx", {ret_pc, ret_x, ret_a, ret_cc} === 40'h1234_55_66_0A,
            {ret_x, ret_a}, 16'h5566);

        // R9 request while busy is ignored
        sp_save = sp_out;
        pc_in = 16'hA5C3;
        @(negedge clk); req_valid = 1'b1; req_op = 3'd3;
        @(negedge clk); req_op = 3'd1; push_data = 8'h77;
        @(negedge clk); req_valid = 1'b0; req_op = 3'd0;
        chk("R9", "busy request ignored", sp_out === sp_save - 16'd2, sp_out, sp_save - 16'd2);
        do_op(3'd4, 0);
        chk("R9", "call intact", ret_pc === 16'hA5C3, ret_pc, 16'hA5C3);
        sp_save = sp_out;
        @(negedge clk); req_valid = 1'b1; req_op = 3'd0;
        @(negedge clk); req_valid = 1'b0;
        chk("R9", "nop no done", !done && sp_out === sp_save, sp_out, sp_save);

        // R5 low byte load
        @(negedge clk); sp_ld = 1'b1; sp_ld_val = 8'h85;
        @(negedge clk); sp_ld = 1'b0;
        chk("R5", "load low", sp_out === 16'h0185, sp_out, 16'h0185);
        @(negedge clk); sp_ld = 1'b1; sp_ld_val = 8'h10; req_valid = 1'b1; req_op = 3'd1; push_data = 8'h99;
        @(negedge clk); sp_ld = 1'b0; req_valid = 1'b0; req_op = 3'd0;
        chk("R5", "load ignored with req", sp_out === 16'h0184, sp_out, 16'h0184);
        @(negedge clk); sp_ld = 1'b1; sp_ld_val = 8'h00;
        @(negedge clk); sp_ld = 1'b0;
        do_op(3'd1, 8'hC4);
        chk("R3", "wrap down", sp_out === 16'h01FF, sp_out, 16'h01FF);
        do_op(3'd2, 0);
        chk("R3", "wrap up", sp_out === 16'h0180 && pop_data === 8'hC4, pop_data, 8'hC4);

        // R4 reset stack pointer
        do_op(3'd7, 0);
        chk("R4", "rsp top", sp_out === 16'h01FF, sp_out, 16'h01FF);

        // R3 129 back-to-back pushes then pops
        for (int i = 0; i < 129; i++) begin
            @(negedge clk); req_valid = 1'b1; req_op = 3'd1; push_data = 8'(i + 1);
        end
        @(negedge clk); req_valid = 1'b0; req_op = 3'd0;
        chk("R3", "129 pushes", sp_out === 16'h01FE, sp_out, 16'h01FE);
        @(negedge clk); req_valid = 1'b1; req_op = 3'd2;
        @(negedge clk); req_valid = 1'b0; req_op = 3'd0;
        chk("R3", "overwritten top", pop_data === 8'd129, pop_data, 8'd129);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk); req_valid = 1'b1; req_op = 3'd2;
        end
        @(negedge clk); req_valid = 1'b0; req_op = 3'd0;
        chk("R3", "back at top", sp_out === 16'h01FF, sp_out, 16'h01FF);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule